// File: doc/BRIEF.md
# I2C Bus Status Monitor

This block listens passively to the clock and data lines of a multi-master I2C bus and keeps one 8-bit status/control register. A CPU reads and writes that register through a single-cycle port. Each line passes through a two-flop synchronizer and then a glitch filter. The filter's hold time can be set to 0, 1, 2 or 3 clock periods.

Start and stop conditions are detected on the filtered lines, and they drive a bus-busy flag. After each start, the block shifts in the first byte and compares it with an own-address input. It flags a match with that address, or a general call (an all-zero byte). It also keeps the level of the acknowledge bit from the ninth clock pulse.

An operation-done flag is raised at the end of every byte and on every stop. When the interrupt enable is set, this flag drives an interrupt output. A separate master engine reports lost arbitration through a one-cycle strobe, and the block holds that event as a flag.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset the register reads 0x00 and `irq_o` is 0.
- R2: A write stores bits 7:6 (filter select, read back in bits 7:6) and bit 4 (interrupt enable, not readable). Written values of bits 5 and 3:0 have no effect on the register.
- R3: Bit 5 (busy) becomes 1 after a start condition and 0 after a stop condition.
- R4: Bit 0 holds the SDA level sampled on the ninth SCL rising edge of a byte. 1 means no acknowledge and 0 means acknowledge.
- R5: Bit 1 (general call) becomes 1 when the first byte after a start is 0x00. It is cleared by any start or stop condition.
- R6: Bit 2 (address match) becomes 1 when bits 7:1 of the first byte after a start equal `own_addr_i`, with bit 0 (the direction bit) ignored. It is cleared by any start or stop condition, and later bytes never set it.
- R7: Bit 3 (arbitration lost) becomes 1 one cycle after an `arb_lost_i` strobe. It stays 1 through stops and writes until the next start condition.
- R8: Bit 4 reads the operation-done flag. The flag becomes 1 on the eighth SCL rising edge of every byte and on every stop condition. Any register write clears it.
- R9: `irq_o` is 1 exactly when the operation-done flag and the interrupt enable are both 1.
- R10: With filter select N, an SDA low pulse of W clock cycles reaches the detectors only if W is at least max(N,1). A pulse while SCL is high that passes the filter produces a start and a stop, and so sets operation-done.
- R11: A start is filtered SDA falling while filtered SCL stays high. A stop is filtered SDA rising while filtered SCL stays high. Bits are shifted MSB first on filtered SCL rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Raw SCL line |
| sda_i | input | 1 | Raw SDA line |
| own_addr_i | input | ADDR_W | Own slave address compared against the first byte |
| arb_lost_i | input | 1 | One-cycle arbitration-lost strobe from the master engine |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the SCL and SDA levels change far more slowly than the system clock, except for deliberate filter probes. They also assume that SDA changes only while SCL is low, except at start and stop, so that a clock edge never coincides with a start or stop. The bench keeps to this by holding every bus phase for eight clock cycles and by moving SDA only in the low half of each bit. The only glitches it drives are short SDA pulses on an idle bus, with all filter settings swept.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned N_LINES = 2;
  localparam int unsigned LINE_SCL = 0;
  localparam int unsigned LINE_SDA = 1;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic sda;
  } bus_evt_t;
endpackage

// File: rtl/i2cmon_line_filter.sv
module i2cmon_line_filter #(
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             raw,
  output logic             filt
);
  localparam logic [SEL_W-1:0] ONE = {{(SEL_W-1){1'b0}}, 1'b1};

  logic [STAGES-1:0] sync_q;
  logic              s;
  logic              out_q, out_d;
  logic [SEL_W-1:0]  cnt_q, cnt_d;

  assign s = sync_q[STAGES-1];

  always_comb begin
    out_d = out_q;
    cnt_d = cnt_q;
    if (sel == '0) begin
      out_d = s;
      cnt_d = '0;
    end else if (s == out_q) begin
      cnt_d = '0;
    end else if (cnt_q == sel - ONE) begin
      out_d = s;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      out_q  <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], raw};
      out_q  <= out_d;
      cnt_q  <= cnt_d;
    end
  end

  assign filt = (sel == '0) ? s : out_q;

  // R10: a filtered change always takes the level the synchronizer held
  p_change_tracks_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != '0 && $stable(sel) && !$stable(out_q)) |-> (out_q == $past(s)));
endmodule

// File: rtl/i2cmon_bus_cond.sv
module i2cmon_bus_cond
  import i2cmon_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl,
  input  logic     sda,
  output bus_evt_t evt
);
  logic scl_p_q, sda_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl;
      sda_p_q <= sda;
    end
  end

  always_comb begin
    evt.start    = scl & scl_p_q & sda_p_q & ~sda;
    evt.stop     = scl & scl_p_q & ~sda_p_q & sda;
    evt.scl_rise = scl & ~scl_p_q;
    evt.sda      = sda;
  end

  // R11: a start is only ever reported while SCL was high on the cycle before
  p_start_scl_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt.start |-> $past(scl));
endmodule

// File: rtl/i2cmon_byte_rx.sv
module i2cmon_byte_rx
  import i2cmon_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              byte_done,
  output logic              gcall_hit,
  output logic              amatch_hit,
  output logic              ack_valid,
  output logic              ack_bit
);
  localparam int unsigned DATA_W = ADDR_W + 1;
  localparam int unsigned CNT_W  = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);

  logic              active_q, active_d;
  logic              addr_ph_q, addr_ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] full_byte;
  logic              edge_ok;
  logic              addr_done;

  assign edge_ok   = evt.scl_rise & active_q & ~evt.start & ~evt.stop;
  assign full_byte = {sh_q[DATA_W-2:0], evt.sda};
  assign byte_done = edge_ok & (cnt_q == LAST_BIT);
  assign addr_done = byte_done & addr_ph_q;
  assign gcall_hit = addr_done & (full_byte == '0);
  assign amatch_hit = addr_done & (full_byte[DATA_W-1:1] == own_addr);
  assign ack_valid = edge_ok & (cnt_q == ACK_SLOT);
  assign ack_bit   = evt.sda;

  always_comb begin
    active_d  = active_q;
    addr_ph_d = addr_ph_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    if (evt.start) begin
      active_d  = 1'b1;
      addr_ph_d = 1'b1;
      cnt_d     = '0;
    end else if (evt.stop) begin
      active_d  = 1'b0;
      addr_ph_d = 1'b0;
      cnt_d     = '0;
    end else if (edge_ok) begin
      if (cnt_q == ACK_SLOT) begin
        cnt_d     = '0;
        addr_ph_d = 1'b0;
      end else begin
        sh_d  = full_byte;
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      addr_ph_q <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
    end else begin
      active_q  <= active_d;
      addr_ph_q <= addr_ph_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
    end
  end

  // R4: the bit counter never runs past the acknowledge slot
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ACK_SLOT);
  // R6: the address phase ends once the acknowledge slot has been taken
  p_addr_phase_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !evt.start) |=> !addr_ph_q);
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2cmon_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              arb_lost_i,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic rst_meta_q, rst_sync_q, rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_n_int = rst_sync_q;

  logic [SEL_W-1:0]   sel_q, sel_d;
  logic               ie_q, ie_d;
  logic               busy_q, busy_d;
  logic               done_q, done_d;
  logic               arb_q, arb_d;
  logic               am_q, am_d;
  logic               gc_q, gc_d;
  logic               lrb_q, lrb_d;

  logic [N_LINES-1:0] raw_lines, filt_lines;
  bus_evt_t           evt;
  logic               byte_done, gcall_hit, amatch_hit, ack_valid, ack_bit;

  assign raw_lines[LINE_SCL] = scl_i;
  assign raw_lines[LINE_SDA] = sda_i;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    i2cmon_line_filter #(.SEL_W(SEL_W), .STAGES(SYNC_STAGES)) u_filt (
      .clk  (clk),
      .rst_n(rst_n_int),
      .sel  (sel_q),
      .raw  (raw_lines[i]),
      .filt (filt_lines[i])
    );
  end

  i2cmon_bus_cond u_cond (
    .clk  (clk),
    .rst_n(rst_n_int),
    .scl  (filt_lines[LINE_SCL]),
    .sda  (filt_lines[LINE_SDA]),
    .evt  (evt)
  );

  i2cmon_byte_rx #(.ADDR_W(ADDR_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .evt       (evt),
    .own_addr  (own_addr_i),
    .byte_done (byte_done),
    .gcall_hit (gcall_hit),
    .amatch_hit(amatch_hit),
    .ack_valid (ack_valid),
    .ack_bit   (ack_bit)
  );

  always_comb begin
    sel_d  = sel_q;
    ie_d   = ie_q;
    busy_d = busy_q;
    done_d = done_q;
    arb_d  = arb_q;
    am_d   = am_q;
    gc_d   = gc_q;
    lrb_d  = lrb_q;
    if (reg_wr_i) begin
      sel_d  = reg_wdata_i[7:6];
      ie_d   = reg_wdata_i[4];
      done_d = 1'b0;
    end
    if (evt.start) busy_d = 1'b1;
    if (evt.stop)  busy_d = 1'b0;
    if (byte_done || evt.stop) done_d = 1'b1;
    if (evt.start) arb_d = 1'b0;
    if (arb_lost_i) arb_d = 1'b1;
    if (evt.start || evt.stop) begin
      am_d = 1'b0;
      gc_d = 1'b0;
    end
    if (amatch_hit) am_d = 1'b1;
    if (gcall_hit)  gc_d = 1'b1;
    if (ack_valid)  lrb_d = ack_bit;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      sel_q  <= '0;
      ie_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      arb_q  <= 1'b0;
      am_q   <= 1'b0;
      gc_q   <= 1'b0;
      lrb_q  <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      ie_q   <= ie_d;
      busy_q <= busy_d;
      done_q <= done_d;
      arb_q  <= arb_d;
      am_q   <= am_d;
      gc_q   <= gc_d;
      lrb_q  <= lrb_d;
    end
  end

  assign reg_rdata_o = {sel_q, busy_q, done_q, arb_q, am_q, gc_q, lrb_q};
  assign irq_o       = done_q & ie_q;

  p_busy_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    evt.start |=> busy_q);
  p_busy_off_stop_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    evt.stop |=> !busy_q);
  p_gcall_clear_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (evt.start || evt.stop) |=> !gc_q);
  p_amatch_clear_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (evt.start || evt.stop) |=> !am_q);
  p_arb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (arb_q && !evt.start) |=> arb_q);
  p_done_wr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (reg_wr_i && !byte_done && !evt.stop) |=> !done_q);
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(irq_o) |-> ($rose(done_q) || $rose(ie_q)));
  p_ro_bits_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (reg_wr_i && !evt.start && !evt.stop && !byte_done && !ack_valid && !arb_lost_i
     && (reg_wdata_i[3:0] != reg_rdata_o[3:0] || reg_wdata_i[5] != busy_q))
    |=> ($stable(reg_rdata_o[3:0]) && $stable(busy_q)));
endmodule

// File: tb/tb_i2c_bus_monitor.sv
module tb_i2c_bus_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;
  localparam logic [6:0] OWN = 7'h2A;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_i, sda_i, arb_lost_i, reg_wr_i;
  logic [6:0] own_addr_i;
  logic [7:0] reg_wdata_i, reg_rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_bus_monitor dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .own_addr_i(own_addr_i), .arb_lost_i(arb_lost_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr_i = 1'b1;
    reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic bus_start();
    sda_i = 1'b1; cyc(H);
    scl_i = 1'b1; cyc(H);
    sda_i = 1'b0; cyc(H);
    scl_i = 1'b0; cyc(H);
  endtask

  task automatic bus_stop();
    sda_i = 1'b0; cyc(H);
    scl_i = 1'b1; cyc(H);
    sda_i = 1'b1; cyc(H);
  endtask

  task automatic send_bit(input logic b);
    sda_i = b; cyc(H);
    scl_i = 1'b1; cyc(H);
    scl_i = 1'b0; cyc(H);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  initial begin
    cyc(150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; scl_i = 1'b1; sda_i = 1'b1; arb_lost_i = 1'b0;
    reg_wr_i = 1'b0; reg_wdata_i = '0; own_addr_i = OWN;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset state
    chk("R1 rdata", reg_rdata_o, 8'h00);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);

    // R2 write all ones: only filter select readable, status bits untouched
    wr(8'hFF);
    chk("R2 write ff", reg_rdata_o, 8'hC0);
    chk("R2 irq no done", {7'b0, irq_o}, 8'h00);
    wr(8'h00);
    chk("R2 write 00", reg_rdata_o, 8'h00);

    // R7 arbitration flag
    arb_lost_i = 1'b1; @(negedge clk); arb_lost_i = 1'b0;
    chk("R7 arb set", reg_rdata_o, 8'h08);
    wr(8'h00);
    chk("R7 R2 arb survives write", reg_rdata_o, 8'h08);
    bus_start();
    chk("R7 arb cleared by start", reg_rdata_o & 8'h08, 8'h00);
    chk("R3 busy after start", reg_rdata_o & 8'h20, 8'h20);
    arb_lost_i = 1'b1; @(negedge clk); arb_lost_i = 1'b0;
    bus_stop();
    chk("R7 arb survives stop", reg_rdata_o & 8'h28, 8'h08);
    bus_start();
    chk("R7 arb cleared again", reg_rdata_o & 8'h08, 8'h00);
    bus_stop();

    // R9 interrupt enable and done
    wr(8'h10);
    chk("R2 R8 ie not readable", reg_rdata_o, 8'h00);
    bus_start();
    send_byte(8'h54);
    chk("R8 done after byte", reg_rdata_o & 8'h10, 8'h10);
    chk("R9 irq with ie", {7'b0, irq_o}, 8'h01);
    wr(8'h10);
    chk("R9 irq cleared by write", {7'b0, irq_o}, 8'h00);
    send_bit(1'b0);
    bus_stop();
    chk("R9 irq on stop", {7'b0, irq_o}, 8'h01);
    wr(8'h00);
    chk("R9 irq off when disabled", {7'b0, irq_o}, 8'h00);

    // R4 R5 R6 R8 sweep of every address
    for (int a = 0; a < 128; a++) begin
      logic [7:0] b;
      logic       ack, gc, am;
      b   = {a[6:0], a[2]};
      ack = a[1];
      gc  = (b == 8'h00);
      am  = (a[6:0] == OWN);
      wr(8'h00);
      bus_start();
      chk("R3 busy in sweep", reg_rdata_o & 8'h20, 8'h20);
      send_byte(b);
      chk("R8 done at byte end", reg_rdata_o & 8'h10, 8'h10);
      chk("R9 no irq without ie", {7'b0, irq_o}, 8'h00);
      send_bit(ack);
      chk("R4 R5 R6 flags", reg_rdata_o & 8'h07, {5'b0, am, gc, ack});
      wr(8'h00);
      chk("R8 write clears done", reg_rdata_o & 8'h10, 8'h00);
      bus_stop();
      chk("R3 R5 R6 R8 after stop", reg_rdata_o, {3'b000, 1'b1, 3'b000, ack});
    end

    // R6 data byte after a general call does not match
    bus_start();
    send_byte(8'h00);
    send_bit(1'b0);
    wr(8'h00);
    send_byte({OWN, 1'b0});
    chk("R6 data byte ignored", reg_rdata_o & 8'h16, 8'h12);
    send_bit(1'b1);
    chk("R4 nack", reg_rdata_o & 8'h01, 8'h01);

    // R6 R11 repeated start clears the flags, direction bit ignored
    bus_start();
    chk("R5 gcall cleared by repeated start", reg_rdata_o & 8'h26, 8'h20);
    send_byte({OWN, 1'b1});
    send_bit(1'b0);
    chk("R6 match with read bit", reg_rdata_o & 8'h07, 8'h04);
    bus_start();
    chk("R6 match cleared by repeated start", reg_rdata_o & 8'h24, 8'h20);
    bus_stop();

    // R10 filter sweep with SDA pulses on an idle bus
    for (int n = 0; n < 4; n++) begin
      for (int w = 1; w <= 5; w++) begin
        int    th;
        logic  pass;
        th   = (n == 0) ? 1 : n;
        pass = (w >= th);
        wr({n[1:0], 6'b0});
        chk("R2 R10 select readback", reg_rdata_o & 8'hC0, {n[1:0], 6'b0});
        cyc(10);
        sda_i = 1'b0; cyc(w);
        sda_i = 1'b1; cyc(20);
        chk("R10 R11 pulse passes", {7'b0, reg_rdata_o[4]}, {7'b0, pass});
        chk("R10 busy idle", reg_rdata_o & 8'h20, 8'h00);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule